// File: doc/BRIEF.md
# Serial Command and Readout Front End for a Multichannel Sampling Converter

This block is the digital serial port of a multichannel successive-approximation converter. While chip select is low, the host clocks in an 8-bit command on the data input, one bit per serial-clock rising edge, MSB first. The block decodes the command into channel, scan, power-down and clock-source fields. It raises a channel strobe and a sample strobe at fixed serial-clock edge numbers. It then shifts the 14-bit straight-binary result, followed by two sub-bits, out on the data output, one bit per falling edge.

A pin selects the frame length. The narrow frame is 24 serial clocks. The wide frame is 32 serial clocks: acquisition runs eight clocks longer and the result starts eight clocks later. If chip select rises before a frame ends, the frame is aborted. The power-down selection is applied only when chip select rises.

The serial clock, the chip select and the data input are all synchronised into a faster system clock. Edges are detected in that clock domain, and the serial clock is never used as a clock. The converter result enters on a parallel port, which a behavioural model drives.

Top module: `adc_serial_front`

## Requirements
- R1: After reset the command fields read 0x06: channel 0, scan 0, power-down select 3, clock-source bit 0. The applied power-down state is 3, the output enable is low and busy is low.
- R2: The eight bits sampled on serial-clock rising edges 1 to 8 after chip select falls form the command, MSB first. On the 8th rising edge they are loaded as channel [7:5], scan [4:3], power-down select [2:1] and clock source [0].
- R3: On the 3rd rising edge, the first three command bits are latched as the active channel, and a one-cycle channel strobe is given.
- R4: Exactly one one-cycle sample strobe is given per frame. It follows falling edge 6 in narrow mode and falling edge 14 in wide mode. The converter data and sub-bits are captured at that instant, and later changes on the converter port do not alter the result.
- R5: While chip select is low, the output is enabled and drives 0 until the first result bit. The result MSB appears after falling edge 8 (narrow) or 16 (wide). The bits follow D13 down to D0, then S1 and S0, one per falling edge.
- R6: Serial clocks beyond the 16 result bits drive 0 on the output until chip select rises.
- R7: Busy rises on the first rising edge of a frame. It falls on falling edge 24 (narrow) or 32 (wide).
- R8: If chip select rises while busy, a one-cycle abort pulse is given and busy clears. A command that was cut off before its 8th bit leaves the command fields unchanged.
- R9: The applied power-down state takes the power-down select field when chip select rises, and at no other time.
- R10: While chip select is high, the output enable is low and serial-clock edges have no effect on the command fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial command input |
| wide_sel | input | 1 | 1 selects the 32-clock frame |
| conv_data | input | DATA_W | Converter result |
| conv_sub | input | SUB_W | Converter sub-bits |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for dout (0 = high-Z) |
| cfg_chan | output | 3 | Command channel field |
| cfg_scan | output | 2 | Command scan field |
| cfg_pd | output | 2 | Command power-down select field |
| cfg_intclk | output | 1 | Command clock-source bit |
| act_chan | output | 3 | Channel latched on the 3rd rising edge |
| chan_stb | output | 1 | Channel-select strobe |
| sample_stb | output | 1 | Sample/convert-start strobe |
| busy | output | 1 | Frame in progress |
| abort | output | 1 | Frame aborted by chip select |
| pd_state | output | 2 | Applied power-down mode |

## Verification
The bench builds the block with its default parameters: a 14-bit result, two sub-bits, a sample edge of 6, an 8-clock wide extension and two synchroniser stages. With these values both the 24-clock and the 32-clock frame fit inside the 6-bit edge counter, with room for extra clocks. A six-system-clock serial half period covers the synchroniser and edge-detect latency. This lets every strobe and output bit be checked at a known serial edge index. Aborts are placed both before and after the command load, so both outcomes of a cut-off command can be checked.

// File: rtl/adc_serial_front.sv
module adc_serial_front #(
  parameter int DATA_W      = 14,
  parameter int SUB_W       = 2,
  parameter int SAMPLE_EDGE = 6,
  parameter int WIDE_EXTRA  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [SUB_W-1:0]  conv_sub,
  output logic              dout,
  output logic              dout_oe,
  output logic [2:0]        cfg_chan,
  output logic [1:0]        cfg_scan,
  output logic [1:0]        cfg_pd,
  output logic              cfg_intclk,
  output logic [2:0]        act_chan,
  output logic              chan_stb,
  output logic              sample_stb,
  output logic              busy,
  output logic              abort,
  output logic [1:0]        pd_state
);

  localparam int CMD_W   = 8;
  localparam int OUT_W   = DATA_W + SUB_W;
  localparam int CNT_W   = $clog2(CMD_W + WIDE_EXTRA + OUT_W + 4);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, din_sy;
  logic sclk_q, cs_q;
  logic [CNT_W-1:0] rcnt;
  logic [CMD_W-1:0] cmd, cmd_sh;
  logic [OUT_W-1:0] res, osr;

  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire cs_s   = cs_sy[SYNC_STAGES-1];
  wire din_s  = din_sy[SYNC_STAGES-1];
  wire rise   = sclk_s & ~sclk_q;
  wire fall   = ~sclk_s & sclk_q;

  wire [CNT_W-1:0] samp_edge = wide_sel ? CNT_W'(SAMPLE_EDGE + WIDE_EXTRA) : CNT_W'(SAMPLE_EDGE);
  wire [CNT_W-1:0] first_out = wide_sel ? CNT_W'(CMD_W + WIDE_EXTRA) : CNT_W'(CMD_W);
  wire [CNT_W-1:0] frame_len = first_out + CNT_W'(OUT_W);

  assign {cfg_chan, cfg_scan, cfg_pd, cfg_intclk} = cmd;
  assign dout_oe = ~cs_s;
  assign dout    = osr[OUT_W-1] & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy    <= '0;
      cs_sy      <= '1;
      din_sy     <= '0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      rcnt       <= '0;
      cmd        <= 8'h06;
      cmd_sh     <= '0;
      res        <= '0;
      osr        <= '0;
      act_chan   <= '0;
      chan_stb   <= 1'b0;
      sample_stb <= 1'b0;
      busy       <= 1'b0;
      abort      <= 1'b0;
      pd_state   <= 2'b11;
    end else begin
      sclk_sy    <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      cs_sy      <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      din_sy     <= {din_sy[SYNC_STAGES-2:0], din};
      sclk_q     <= sclk_s;
      cs_q       <= cs_s;
      chan_stb   <= 1'b0;
      sample_stb <= 1'b0;
      abort      <= 1'b0;
      if (cs_s) begin
        rcnt <= '0;
        osr  <= '0;
        busy <= 1'b0;
        if (!cs_q) begin
          abort    <= busy;
          pd_state <= cmd[2:1];
        end
      end else begin
        if (rise && rcnt != CNT_MAX) begin
          rcnt   <= rcnt + 1'b1;
          cmd_sh <= {cmd_sh[CMD_W-2:0], din_s};
          if (rcnt == '0) busy <= 1'b1;
          if (rcnt == CNT_W'(2)) begin
            act_chan <= {cmd_sh[1:0], din_s};
            chan_stb <= 1'b1;
          end
          if (rcnt == CNT_W'(CMD_W - 1)) cmd <= {cmd_sh[CMD_W-2:0], din_s};
        end
        if (fall && busy) begin
          if (rcnt == samp_edge) begin
            res        <= {conv_data, conv_sub};
            sample_stb <= 1'b1;
          end
          if (rcnt == first_out) osr <= res;
          else                   osr <= {osr[OUT_W-2:0], 1'b0};
          if (rcnt == frame_len) busy <= 1'b0;
        end
      end
    end
  end

endmodule

module adc_serial_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dout_oe,
  input logic       busy,
  input logic       abort,
  input logic       chan_stb,
  input logic       sample_stb,
  input logic [1:0] pd_state,
  input logic [7:0] cfg
);
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_stb, sample_stb, abort})); // R4
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R4
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy); // R7
  AST_ABORT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy); // R8
  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_oe && $past(!dout_oe)) |-> !busy); // R10
  AST_PD_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_state) |-> !dout_oe); // R9
  AST_CFG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cfg)); // R2
endmodule

bind adc_serial_front adc_serial_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout_oe(dout_oe), .busy(busy), .abort(abort),
  .chan_stb(chan_stb), .sample_stb(sample_stb), .pd_state(pd_state),
  .cfg({cfg_chan, cfg_scan, cfg_pd, cfg_intclk})
);

// File: tb/sim_adc_serial_front.sv
module sim_adc_serial_front;
  localparam int H = 6;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, din = 0, wide_sel = 0;
  logic [13:0] conv_data = '0;
  logic [1:0]  conv_sub = '0;
  logic dout, dout_oe, cfg_intclk, chan_stb, sample_stb, busy, abort;
  logic [2:0] cfg_chan, act_chan;
  logic [1:0] cfg_scan, cfg_pd, pd_state;

  int total = 0, bad = 0;
  int rise_idx = 0, fall_idx = 0, n_samp = 0, samp_at = 0, n_chan = 0, chan_at = 0, n_abort = 0;
  logic [7:0] exp_cmd = 8'h06;
  logic [1:0] exp_pd = 2'b11;

  always #4 clk = ~clk;

  adc_serial_front u0 (.*);

  always @(posedge clk) begin
    if (sample_stb) begin n_samp <= n_samp + 1; samp_at <= fall_idx; end
    if (chan_stb)   begin n_chan <= n_chan + 1; chan_at <= rise_idx; end
    if (abort)      n_abort <= n_abort + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic d, output logic got);
    din = d; waitn(H);
    sclk = 1; rise_idx++; waitn(H);
    sclk = 0; fall_idx++; waitn(H);
    got = dout;
  endtask

  function automatic logic exp_bit(input int k, input int f, input logic [15:0] w);
    if (k >= f && k < f + 16) return w[15 - (k - f)];
    return 1'b0;
  endfunction

  task automatic frame(input logic [7:0] c, input bit wide, input logic [13:0] d,
                       input logic [1:0] s, input int nclk, input int abort_k);
    int f, sm, l, last;
    logic got;
    logic [15:0] w;
    f = wide ? 16 : 8; sm = wide ? 14 : 6; l = f + 16;
    last = (abort_k != 0) ? abort_k : nclk;
    w = {d, s};
    wide_sel = wide; conv_data = d; conv_sub = s;
    rise_idx = 0; fall_idx = 0; n_samp = 0; n_chan = 0; n_abort = 0;
    cs_n = 0; waitn(H);
    chk("R5 oe on select", dout_oe, 1);
    chk("R5 low on select", dout, 0);
    for (int k = 1; k <= last; k++) begin
      tick(k <= 8 ? c[8-k] : 1'($urandom), got);
      chk(k >= f + 16 ? "R6 trailing zero" : "R5 dout bit", got, exp_bit(k, f, w));
      if (k == sm) conv_data = 14'($urandom);
      if (k == 1) chk("R7 busy rise", busy, 1);
      if (k == 3) begin
        chk("R3 act_chan", act_chan, c[7:5]);
        chk("R3 chan edge", chan_at, 3);
      end
      if (k == 8) chk("R2 cmd fields", {cfg_chan, cfg_scan, cfg_pd, cfg_intclk}, c);
      if (k == l) chk("R7 busy fall", busy, 0);
    end
    if (last >= 8) exp_cmd = c;
    chk("R9 pd held while selected", pd_state, exp_pd);
    chk("R4 sample count", n_samp, last >= sm ? 1 : 0);
    if (last >= sm) chk("R4 sample edge", samp_at, sm);
    cs_n = 1; waitn(2 * H);
    exp_pd = exp_cmd[2:1];
    chk("R10 oe off", dout_oe, 0);
    chk("R8 abort pulse", n_abort, last < l ? 1 : 0);
    chk("R8 busy clear", busy, 0);
    chk("R8 cmd kept", {cfg_chan, cfg_scan, cfg_pd, cfg_intclk}, exp_cmd);
    chk("R9 pd applied", pd_state, exp_pd);
    for (int j = 0; j < 3; j++) tick(1'($urandom), got);
    chk("R10 edges ignored", {cfg_chan, cfg_scan, cfg_pd, cfg_intclk}, exp_cmd);
    chk("R10 no sample", n_samp, last >= sm ? 1 : 0);
    waitn(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240607);
    waitn(4); rst_n = 1; waitn(4);
    chk("R1 cmd reset", {cfg_chan, cfg_scan, cfg_pd, cfg_intclk}, 8'h06);
    chk("R1 pd reset", pd_state, 3);
    chk("R1 oe reset", dout_oe, 0);
    chk("R1 busy reset", busy, 0);
    frame(8'hB9, 0, 14'h3FFF, 2'b11, 24, 0);
    frame(8'h52, 1, 14'h2AAA, 2'b01, 32, 0);
    frame(8'hE3, 0, 14'h1234, 2'b10, 28, 0);
    frame(8'h7C, 0, 14'h0F0F, 2'b00, 24, 4);
    frame(8'h2A, 1, 14'h3001, 2'b11, 32, 20);
    frame(8'h01, 0, 14'h0001, 2'b00, 24, 7);
    for (int i = 0; i < 12; i++) begin
      bit wd;
      int n, ab;
      wd = 1'($urandom);
      n  = (wd ? 32 : 24) + int'($urandom % 4);
      ab = ($urandom % 4 == 0) ? 1 + int'($urandom % (wd ? 31 : 23)) : 0;
      frame(8'($urandom), wd, 14'($urandom), 2'($urandom), n, ab);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule